// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers up to 32 single-cycle event pulses from device functions into a sticky status register. It drives one level-sensitive interrupt line to the host whenever a pending status bit is not blocked by the mask.

The host reaches the block through a small register interface with an address, a write enable, write data, a read enable and read data. Six register addresses are decoded:

| Address | Register | Access | Effect |
|---|---|---|---|
| 0 | Full mask | read/write | Holds the whole mask word |
| 1 | Mask set | write only | Sets the mask bits written as 1 |
| 2 | Mask clear | write only | Clears the mask bits written as 1 |
| 3 | Status peek | read only | Shows pending bits and leaves them intact |
| 4 | Status take | read only | Returns pending bits and empties the whole status |
| 5 | Acknowledge | write only | Retires the pending bits written as 1 |

Source positions in the default configuration:

- 0: receive buffer 0 ready
- 1: transmit data
- 2: transmit transfer
- 3: receive buffer 1 ready
- 4: receive transfer
- 5 and 6: the two event mailbox sources
- 7: wake
- 8 and 9: the two trace sources
- 10: command done
- 14: init done
- 16: coexistence sense on
- 17: coexistence sense off

All other positions are unused. The `VALID_MASK` parameter records which positions are in use.

Top module: `hint_status_ctrl`

## Requirements
- R1: `irq_out` is active while at least one status bit is 1 and its mask bit is 0. A status bit whose mask bit is 1 never makes `irq_out` active.
- R2: After reset the mask holds 0x0000_0001, the status is zero and `irq_out` is inactive.
- R3: A write to address 0 loads the whole mask word. A read of address 0 returns the mask.
- R4: A write to address 1 sets each mask bit written as 1. Mask bits written as 0 keep their value.
- R5: A write to address 2 clears each mask bit written as 1. Mask bits written as 0 keep their value.
- R6: A one-cycle pulse on a used `src_evt` bit sets the matching status bit. The bit stays 1 until it is acknowledged or taken.
- R7: A read of address 3 returns the status and leaves it unchanged.
- R8: A read of address 4 returns the status and then clears every status bit.
- R9: A write to address 5 clears each status bit written as 1. Status bits written as 0 keep their value.
- R10: When a source pulse arrives in the same cycle as an acknowledge or a take of that bit, the bit ends up set.
- R11: Unused positions of the status (those where `VALID_MASK` is 0) always read 0, even when their `src_evt` bit is pulsed.
- R12: `irq_pol_low` set to 0 makes `irq_out` active high. Set to 1, it makes `irq_out` active low.
- R13: `rd_data` carries the addressed value in the cycle after `rd_en` is sampled, and is 0 otherwise. A read of a write-only address (1, 2 or 5) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | NUM_SRC | Event pulses, one per source |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | NUM_SRC | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | NUM_SRC | Read data, one cycle after `rd_en` |
| irq_pol_low | input | 1 | 1 selects an active-low `irq_out` |
| irq_out | output | 1 | Host interrupt level |

## Verification
The bench targets the collision of a new event with an acknowledge, and of a new event with a take. A design that lets the clear win would silently drop that event. It checks that the take returns the pre-clear value and that peek reads leave the status intact. A design that clears on every read would lose pending work on a peek. It pulses every source at once, so that storage in unused positions would show up as extra bits. It writes zero words to the set, clear and acknowledge ports, where a design that treats the write as a plain load would wipe state. It also flips the polarity with work pending and checks that the interrupt line inverts.

// File: rtl/hint_pkg.sv
package hint_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_MASK      = 3'd0,
      RA_MASK_SET  = 3'd1,
      RA_MASK_CLR  = 3'd2,
      RA_STAT_PEEK = 3'd3,
      RA_STAT_TAKE = 3'd4,
      RA_ACK       = 3'd5
   } hint_addr_e;
endpackage

// File: rtl/hint_mask_reg.sv
module hint_mask_reg #(
   parameter int             W         = 32,
   parameter logic [W-1:0]   RESET_VAL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_full,
   input  logic         ld_set,
   input  logic         ld_clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask
);
   logic [W-1:0] mask_nx;

   always_comb begin
      mask_nx = mask;
      if (ld_full)     mask_nx = wdata;
      else if (ld_set) mask_nx = mask | wdata;
      else if (ld_clr) mask_nx = mask & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= RESET_VAL;
      else        mask <= mask_nx;
   end
endmodule

// File: rtl/hint_status_bank.sv
module hint_status_bank #(
   parameter int           W     = 32,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   input  logic [W-1:0] ack_bits,
   input  logic         take_all,
   output logic [W-1:0] status
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (VALID[i]) begin : g_used
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      bit_q <= 1'b0;
            else if (src[i])                 bit_q <= 1'b1;
            else if (take_all || ack_bits[i]) bit_q <= 1'b0;
         end
         assign status[i] = bit_q;
      end else begin : g_unused
         assign status[i] = 1'b0;
      end
   end
endmodule

// File: rtl/hint_irq_out.sv
module hint_irq_out #(
   parameter int W = 32
) (
   input  logic [W-1:0] status,
   input  logic [W-1:0] mask,
   input  logic         pol_low,
   output logic         irq
);
   logic pending;

   assign pending = |(status & ~mask);
   assign irq     = pending ^ pol_low;
endmodule

// File: rtl/hint_status_ctrl.sv
module hint_status_ctrl #(
   parameter int                 NUM_SRC    = 32,
   parameter logic [NUM_SRC-1:0] VALID_MASK = 32'h0003_47FF,
   parameter logic [NUM_SRC-1:0] MASK_RESET = 32'h0000_0001
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         src_evt,
   input  logic [hint_pkg::ADDR_W-1:0] addr,
   input  logic                       wr_en,
   input  logic [NUM_SRC-1:0]         wr_data,
   input  logic                       rd_en,
   output logic [NUM_SRC-1:0]         rd_data,
   input  logic                       irq_pol_low,
   output logic                       irq_out
);
   import hint_pkg::*;

   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_width
      $error("hint_status_ctrl: NUM_SRC must lie in 1..32");
   end

   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] status_q;
   logic [NUM_SRC-1:0] ack_bits;
   logic               take_all;
   logic               wr_mask, wr_mset, wr_mclr;
   logic [NUM_SRC-1:0] rd_mux;

   assign wr_mask  = wr_en && (addr == RA_MASK);
   assign wr_mset  = wr_en && (addr == RA_MASK_SET);
   assign wr_mclr  = wr_en && (addr == RA_MASK_CLR);
   assign ack_bits = (wr_en && (addr == RA_ACK)) ? wr_data : '0;
   assign take_all = rd_en && (addr == RA_STAT_TAKE);

   hint_mask_reg #(.W(NUM_SRC), .RESET_VAL(MASK_RESET)) i_mask (
      .clk(clk), .rst_n(rst_n), .ld_full(wr_mask), .ld_set(wr_mset),
      .ld_clr(wr_mclr), .wdata(wr_data), .mask(mask_q)
   );

   hint_status_bank #(.W(NUM_SRC), .VALID(VALID_MASK)) i_bank (
      .clk(clk), .rst_n(rst_n), .src(src_evt), .ack_bits(ack_bits),
      .take_all(take_all), .status(status_q)
   );

   hint_irq_out #(.W(NUM_SRC)) i_irq (
      .status(status_q), .mask(mask_q), .pol_low(irq_pol_low), .irq(irq_out)
   );

   always_comb begin
      case (addr)
         RA_MASK:                    rd_mux = mask_q;
         RA_STAT_PEEK, RA_STAT_TAKE: rd_mux = status_q;
         default:                    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
      else            rd_data <= '0;
   end
endmodule

// File: rtl/hint_status_chk.sv
module hint_status_chk #(
   parameter int           W     = 32,
   parameter logic [W-1:0] VALID = '1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   addr,
   input logic         wr_en,
   input logic         rd_en,
   input logic [W-1:0] wr_data,
   input logic [W-1:0] src_evt,
   input logic [W-1:0] status_q,
   input logic [W-1:0] mask_q,
   input logic         irq_pol_low,
   input logic         irq_out
);
   // R1, R12: line level follows unmasked pending work and the polarity
   a_r1_irq_active: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status_q & ~mask_q)) |-> (irq_out != irq_pol_low));
   a_r1_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status_q & ~mask_q)) |-> (irq_out == irq_pol_low));

   a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 3'd1) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));
   a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 3'd2) |=> ((mask_q & $past(wr_data)) == '0));

   // R7: a peek with nothing else going on leaves status alone
   a_r7_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 3'd3 && !wr_en && src_evt == '0) |=> $stable(status_q));

   a_r8_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 3'd4) |=> ((status_q & ~$past(src_evt)) == '0));
   a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 3'd5) |=> ((status_q & $past(wr_data) & ~$past(src_evt)) == '0));

   // R6, R10: a captured event is always set in the next cycle
   a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src_evt & VALID)) |=> ((status_q & $past(src_evt & VALID)) == $past(src_evt & VALID)));

   a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~VALID) == '0);
endmodule

bind hint_status_ctrl hint_status_chk #(.W(NUM_SRC), .VALID(VALID_MASK)) i_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .wr_data(wr_data), .src_evt(src_evt), .status_q(status_q), .mask_q(mask_q),
   .irq_pol_low(irq_pol_low), .irq_out(irq_out)
);

// File: tb/test_hint_status_ctrl.sv
module test_hint_status_ctrl;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_evt = '0;
   logic [2:0]   addr = '0;
   logic         wr_en = 1'b0;
   logic [N-1:0] wr_data = '0;
   logic         rd_en = 1'b0;
   logic [N-1:0] rd_data;
   logic         irq_pol_low = 1'b0;
   logic         irq_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic rd_seen = 1'b0;

   logic [N-1:0] exp_q[$];
   string        tag_q[$];

   always #10 clk = ~clk;

   hint_status_ctrl i_hint_status_ctrl (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .irq_pol_low(irq_pol_low), .irq_out(irq_out)
   );

   always @(posedge clk) rd_seen <= rd_en;

   // monitor: compares each read result against the scoreboard
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         logic [N-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rd_data !== e) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string t);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: irq_out=%b expected=%b", t, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [N-1:0] e, input string t);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse(input logic [N-1:0] s);
      src_evt = s;
      @(negedge clk);
      src_evt = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_out, 1'b0, "R2 idle after reset");
      rd(3'd0, 32'h1, "R2 mask reset value");
      rd(3'd3, 32'h0, "R2 status reset value");

      pulse(32'h1);
      chk(irq_out, 1'b0, "R1 masked source 0 kept off line");
      rd(3'd3, 32'h1, "R6 source 0 captured");
      pulse(32'h2);
      chk(irq_out, 1'b1, "R1 unmasked source 1 raises line");
      rd(3'd3, 32'h3, "R6 sticky bits held");

      wr(3'd5, 32'h0);
      rd(3'd3, 32'h3, "R9 zero ack no effect");
      wr(3'd5, 32'h1);
      rd(3'd3, 32'h2, "R9 ack clears only bit 0");
      wr(3'd1, 32'h2);
      rd(3'd0, 32'h3, "R4 mask set merges");
      chk(irq_out, 1'b0, "R1 line drops once bit 1 masked");
      wr(3'd1, 32'h0);
      rd(3'd0, 32'h3, "R4 zero set no effect");
      wr(3'd2, 32'h1);
      rd(3'd0, 32'h2, "R5 mask clear only bit 0");
      wr(3'd2, 32'h2);
      chk(irq_out, 1'b1, "R5 unmask raises line");

      rd(3'd3, 32'h2, "R7 first peek");
      rd(3'd3, 32'h2, "R7 second peek unchanged");
      rd(3'd4, 32'h2, "R8 take returns pending");
      rd(3'd3, 32'h0, "R8 status empty after take");
      chk(irq_out, 1'b0, "R8 line idle after take");

      pulse('1);
      rd(3'd3, 32'h0003_47FF, "R11 unused positions stay zero");
      wr(3'd5, 32'h0003_47FF);
      rd(3'd3, 32'h0, "R9 ack all used bits");

      // same-cycle event and acknowledge on bit 5
      addr = 3'd5; wr_data = 32'h20; wr_en = 1'b1; src_evt = 32'h20;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; src_evt = '0;
      rd(3'd3, 32'h20, "R10 event beats ack");
      // same-cycle event and take on bit 3
      addr = 3'd4; rd_en = 1'b1; src_evt = 32'h8;
      exp_q.push_back(32'h20); tag_q.push_back("R10 take returns pre-event value");
      @(negedge clk);
      rd_en = 1'b0; src_evt = '0;
      @(negedge clk);
      rd(3'd3, 32'h8, "R10 event beats take");

      chk(irq_out, 1'b1, "R12 active high with work pending");
      irq_pol_low = 1'b1;
      #1;
      chk(irq_out, 1'b0, "R12 active low with work pending");
      wr(3'd5, 32'h8);
      chk(irq_out, 1'b1, "R12 active low idle level");
      irq_pol_low = 1'b0;

      wr(3'd0, 32'hA5A5_0F0F);
      rd(3'd0, 32'hA5A5_0F0F, "R3 full mask load");
      rd(3'd1, 32'h0, "R13 write-only address reads zero");
      rd(3'd5, 32'h0, "R13 ack address reads zero");
      checks++;
      if (rd_data !== '0) begin
         errors++;
         $display("FAIL R13 idle rd_data=%h expected=0", rd_data);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule